// File: doc/BRIEF.md
# Calibration Pattern Read Steering for a DDR3-Style Device

This block sits on the device side of a DDR3-style memory, behind the command decoder. It keeps the third mode register and uses it to decide where each read burst gets its data. In normal mode a READ returns whatever the array presents on its data bus. When the controller turns on calibration pattern mode, every READ and READ-with-auto-precharge is answered with a fixed training pattern instead. The controller uses this pattern to line up its capture timing before real traffic starts.

Pattern mode is guarded. It may only be turned on when every bank is idle and the precharge time of the most recent PRE has passed. Once it is on, the only commands accepted are reads, a mode register write that turns the mode off, and RESET. Any other command, including an attempt to set reserved mode register bits, produces a one-cycle error pulse and has no effect. Each bank's precharge time is tracked by a down-counter of configurable length.

Top module: `calib_read_steer`

## Requirements
- R1: After reset `err_o` and `rd_valid_o` are low, pattern mode is off and no bank precharge timer is running.
- R2: A read command (`cmd_i`=2 READ or 3 READ with auto-precharge) starts a burst that is visible from the cycle after the command edge. `rd_valid_o` stays high for exactly 8 cycles. In normal mode `rd_src_o`=0 and `rd_data_o` follows `arr_data_i`.
- R3: A mode register write is `cmd_i`=1 with `ba_i[1:0]`=3, and it selects the steering register. With `addr_i[2]`=1 and `addr_i[1:0]`=0, all later reads return the pattern with `rd_src_o`=1. The pattern drives every data bit to 0 on even beats and to 1 on odd beats, starting with beat 0 at 0.
- R4: When a steering register write has `addr_i[2]`=0, the value of `addr_i[1:0]` has no effect. Reads stay normal and no error is raised.
- R5: A steering register write with any reserved bit nonzero (`ba_i[2]` or `addr_i[15:3]`) raises `err_o` and leaves the register unchanged.
- R6: A write that would turn pattern mode on while any bit of `bank_idle_i` is low raises `err_o`, and the mode stays off.
- R7: A PRE (`cmd_i`=4) to bank `ba_i` starts that bank's timer. An enabling write is refused with `err_o` when it lands TRP_CYC-1 cycles after the PRE edge, and it is accepted when it lands TRP_CYC cycles after.
- R8: In pattern mode the following commands raise `err_o` for one cycle and change nothing: PRE (4), ACT (5), REF (6), power-down entry (7), self-refresh entry (8), a write to another mode register, and a steering register write that keeps bit 2 set or has reserved bits set. NOP (0) is accepted silently.
- R9: In pattern mode, a clean steering register write with `addr_i[2]`=0 returns the block to normal reads without an error.
- R10: RESET (`cmd_i`=9) is accepted in every mode. It clears the steering register to zero, ends any burst in progress from the next cycle, and raises no error.
- R11: In pattern mode, a read with `addr_i[1:0]`-code 01, 10 or 11 stored in the register returns all-zero data with `rd_src_o`=1. It also pulses `err_o` for exactly one cycle, aligned with beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 4 | Decoded command code |
| ba_i | input | 3 | Bank address |
| addr_i | input | 16 | Address bus |
| bank_idle_i | input | 8 | Per-bank idle (precharged) status from the bank state logic |
| arr_data_i | input | 8 | Array read data for the current beat |
| rd_valid_o | output | 1 | Burst beat valid |
| rd_src_o | output | 1 | Read source: 0 array, 1 pattern register |
| rd_data_o | output | 8 | Burst data |
| err_o | output | 1 | Illegal command pulse, one cycle after the command |

## Verification
The bench places an enabling write one cycle before and exactly at the end of a precharge window. A timer that is off by one would accept the early write or refuse the later one. It then sends every command outside the allowed set while pattern mode is on, and after each one it reads back a full burst. This catches a block that flags the command but still acts on it, for example a PRE that reloads a timer or an ACT that drops the mode. It also checks that a RESET in the middle of a burst ends the burst, and that a reserved pattern code gives zeros with a single-cycle error rather than a stale pattern or a held error. The bench confirms that the low address bits are ignored while the enable bit is clear.

// File: rtl/calib_pkg.sv
package calib_pkg;

    typedef enum logic [3:0] {
        CMD_NOP = 4'd0,
        CMD_MRS = 4'd1,
        CMD_RD  = 4'd2,
        CMD_RDA = 4'd3,
        CMD_PRE = 4'd4,
        CMD_ACT = 4'd5,
        CMD_REF = 4'd6,
        CMD_PDN = 4'd7,
        CMD_SLF = 4'd8,
        CMD_RST = 4'd9
    } cmd_e;

    localparam int BURST_LEN  = 8;
    localparam int STEER_REG  = 3;  // bank-address select of the steering register
    localparam int EN_BIT     = 2;  // master enable bit position
    localparam int CODE_W     = 2;  // pattern code field width

endpackage

// File: rtl/bank_ready_tracker.sv
module bank_ready_tracker #(
    parameter int BA_W    = 3,
    parameter int TRP_CYC = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pre_go_i,
    input  logic [BA_W-1:0]   pre_bank_i,
    input  logic [(1<<BA_W)-1:0] bank_idle_i,
    output logic              all_ready_o
);
    localparam int NB   = 1 << BA_W;
    localparam int CW   = (TRP_CYC < 2) ? 1 : $clog2(TRP_CYC);
    localparam logic [CW-1:0] LOAD = CW'((TRP_CYC > 0) ? TRP_CYC - 1 : 0);

    logic [NB-1:0] timer_done;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (pre_go_i && pre_bank_i == BA_W'(b)) begin
                cnt_d = LOAD;
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) cnt_q <= '0;
            else         cnt_q <= cnt_d;
        end

        assign timer_done[b] = (cnt_q == '0);

        assert_pre_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pre_go_i && pre_bank_i == BA_W'(b)) |=> (cnt_q == LOAD))
            else $error("bank timer not loaded by PRE");
    end

    assign all_ready_o = &(bank_idle_i & timer_done);

endmodule

// File: rtl/mr3_guard.sv
module mr3_guard
    import calib_pkg::*;
#(
    parameter int BA_W = 3,
    parameter int AW   = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cmd_valid_i,
    input  logic [3:0]      cmd_i,
    input  logic [BA_W-1:0] ba_i,
    input  logic [AW-1:0]   addr_i,
    input  logic            all_ready_i,
    output logic            rd_go_o,
    output logic            rd_pat_o,
    output logic            rd_zero_o,
    output logic            pre_go_o,
    output logic            rst_go_o,
    output logic            err_o
);
    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic              err;
    } guard_t;

    guard_t st_d, st_q;
    cmd_e   cmd;
    logic   is_steer, rsvd_bad;

    assign cmd      = cmd_e'(cmd_i);
    assign is_steer = (ba_i[1:0] == 2'(STEER_REG));
    assign rsvd_bad = (|ba_i[BA_W-1:2]) | (|addr_i[AW-1:EN_BIT+1]);

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        rd_go_o   = 1'b0;
        rd_pat_o  = 1'b0;
        rd_zero_o = 1'b0;
        pre_go_o  = 1'b0;
        rst_go_o  = 1'b0;
        if (cmd_valid_i) begin
            unique case (cmd)
                CMD_NOP: ;
                CMD_RST: begin
                    rst_go_o = 1'b1;
                    st_d     = '0;
                end
                CMD_RD, CMD_RDA: begin
                    rd_go_o   = 1'b1;
                    rd_pat_o  = st_q.en;
                    rd_zero_o = st_q.en && (st_q.code != '0);
                    st_d.err  = rd_zero_o;
                end
                CMD_MRS: begin
                    if (!is_steer) begin
                        st_d.err = st_q.en;
                    end else if (rsvd_bad) begin
                        st_d.err = 1'b1;
                    end else if (addr_i[EN_BIT]) begin
                        if (st_q.en || !all_ready_i) begin
                            st_d.err = 1'b1;
                        end else begin
                            st_d.en   = 1'b1;
                            st_d.code = addr_i[CODE_W-1:0];
                        end
                    end else begin
                        st_d.en   = 1'b0;
                        st_d.code = addr_i[CODE_W-1:0];
                    end
                end
                CMD_PRE: begin
                    if (st_q.en) st_d.err = 1'b1;
                    else         pre_go_o = 1'b1;
                end
                default: begin
                    st_d.err = st_q.en;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign err_o = st_q.err;

    assert_busy_enable_blocked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_i == 4'(CMD_MRS) && is_steer && !rsvd_bad && addr_i[EN_BIT]
         && !st_q.en && !all_ready_i) |=> (!st_q.en && err_o))
        else $error("enable accepted with a busy bank");

    assert_gated_cmd_flagged_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && st_q.en && (cmd_i inside {4'(CMD_PRE), 4'(CMD_ACT), 4'(CMD_REF),
         4'(CMD_PDN), 4'(CMD_SLF)})) |=> (err_o && st_q.en))
        else $error("disallowed command in pattern mode not flagged");

    assert_reset_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_valid_i && cmd_i == 4'(CMD_RST)) |=> (!st_q.en && !err_o))
        else $error("RESET did not clear the steering register");

endmodule

// File: rtl/burst_path.sv
module burst_path
    import calib_pkg::*;
#(
    parameter int DQ_W = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rd_go_i,
    input  logic            rd_pat_i,
    input  logic            rd_zero_i,
    input  logic            abort_i,
    input  logic [DQ_W-1:0] arr_data_i,
    output logic            rd_valid_o,
    output logic            rd_src_o,
    output logic [DQ_W-1:0] rd_data_o
);
    localparam int BEAT_W = $clog2(BURST_LEN);
    localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BURST_LEN - 1);

    typedef struct packed {
        logic              act;
        logic [BEAT_W-1:0] beat;
        logic              pat;
        logic              zero;
    } burst_t;

    burst_t bs_d, bs_q;

    always_comb begin
        bs_d = bs_q;
        if (abort_i) begin
            bs_d.act = 1'b0;
        end else if (rd_go_i) begin
            bs_d.act  = 1'b1;
            bs_d.beat = '0;
            bs_d.pat  = rd_pat_i;
            bs_d.zero = rd_zero_i;
        end else if (bs_q.act) begin
            if (bs_q.beat == LAST) bs_d.act  = 1'b0;
            else                   bs_d.beat = bs_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bs_q <= '0;
        else         bs_q <= bs_d;
    end

    always_comb begin
        rd_data_o = '0;
        if (bs_q.act) begin
            if (!bs_q.pat)      rd_data_o = arr_data_i;
            else if (!bs_q.zero) rd_data_o = {DQ_W{bs_q.beat[0]}};
        end
    end

    assign rd_valid_o = bs_q.act;
    assign rd_src_o   = bs_q.act & bs_q.pat;

    assert_burst_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && bs_q.beat == LAST && !rd_go_i) |=> !rd_valid_o)
        else $error("burst longer than its length");

    assert_abort_stops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        abort_i |=> !rd_valid_o)
        else $error("burst survived RESET");

endmodule

// File: rtl/calib_read_steer.sv
module calib_read_steer #(
    parameter int BA_W    = 3,
    parameter int AW      = 16,
    parameter int DQ_W    = 8,
    parameter int TRP_CYC = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cmd_valid_i,
    input  logic [3:0]           cmd_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [(1<<BA_W)-1:0] bank_idle_i,
    input  logic [DQ_W-1:0]      arr_data_i,
    output logic                 rd_valid_o,
    output logic                 rd_src_o,
    output logic [DQ_W-1:0]      rd_data_o,
    output logic                 err_o
);
    logic all_ready, rd_go, rd_pat, rd_zero, pre_go, rst_go;

    bank_ready_tracker #(.BA_W(BA_W), .TRP_CYC(TRP_CYC)) u_banks (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pre_go_i    (pre_go),
        .pre_bank_i  (ba_i),
        .bank_idle_i (bank_idle_i),
        .all_ready_o (all_ready)
    );

    mr3_guard #(.BA_W(BA_W), .AW(AW)) u_guard (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cmd_valid_i (cmd_valid_i),
        .cmd_i       (cmd_i),
        .ba_i        (ba_i),
        .addr_i      (addr_i),
        .all_ready_i (all_ready),
        .rd_go_o     (rd_go),
        .rd_pat_o    (rd_pat),
        .rd_zero_o   (rd_zero),
        .pre_go_o    (pre_go),
        .rst_go_o    (rst_go),
        .err_o       (err_o)
    );

    burst_path #(.DQ_W(DQ_W)) u_burst (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rd_go_i    (rd_go),
        .rd_pat_i   (rd_pat),
        .rd_zero_i  (rd_zero),
        .abort_i    (rst_go),
        .arr_data_i (arr_data_i),
        .rd_valid_o (rd_valid_o),
        .rd_src_o   (rd_src_o),
        .rd_data_o  (rd_data_o)
    );

endmodule

// File: tb/tb_calib_read_steer.sv
module tb_calib_read_steer;
    localparam int CLK_PERIOD = 10;
    localparam int TRP        = 5;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd = 4'd0;
    logic [2:0]  ba = 3'd0;
    logic [15:0] addr = 16'd0;
    logic [7:0]  bank_idle = 8'hFF;
    logic [7:0]  arr_data = 8'h00;
    logic        rd_valid, rd_src, err;
    logic [7:0]  rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    calib_read_steer #(.TRP_CYC(TRP)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
        .ba_i(ba), .addr_i(addr), .bank_idle_i(bank_idle), .arr_data_i(arr_data),
        .rd_valid_o(rd_valid), .rd_src_o(rd_src), .rd_data_o(rd_data), .err_o(err)
    );

    typedef struct packed {
        logic [3:0]  c;
        logic [2:0]  b;
        logic [15:0] a;
        logic        e;
    } vec_t;

    // R8: commands sent while pattern mode is on, with the expected error flag
    localparam vec_t TBL [9] = '{
        '{c:4'd4, b:3'd2, a:16'h0000, e:1'b1},   // PRE
        '{c:4'd5, b:3'd1, a:16'h0000, e:1'b1},   // ACT
        '{c:4'd6, b:3'd0, a:16'h0000, e:1'b1},   // REF
        '{c:4'd7, b:3'd0, a:16'h0000, e:1'b1},   // power-down entry
        '{c:4'd8, b:3'd0, a:16'h0000, e:1'b1},   // self-refresh entry
        '{c:4'd1, b:3'd0, a:16'h0000, e:1'b1},   // write to another mode register
        '{c:4'd1, b:3'd3, a:16'h0004, e:1'b1},   // steering write keeping enable
        '{c:4'd1, b:3'd3, a:16'h0008, e:1'b1},   // steering write with reserved bit
        '{c:4'd0, b:3'd0, a:16'h0000, e:1'b0}    // NOP
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // called at a negedge; returns at the negedge after the command edge
    task automatic send(input logic [3:0] c, input logic [2:0] b, input logic [15:0] a);
        cmd_valid = 1'b1; cmd = c; ba = b; addr = a;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 4'd0; ba = 3'd0; addr = 16'd0;
    endtask

    task automatic read_chk(input string req, input logic [3:0] c, input logic pat,
                            input logic zero, input logic exp_err);
        send(c, 3'd0, 16'h0000);
        for (int k = 0; k < 8; k++) begin
            arr_data = 8'h3C ^ 8'(k * 17);
            #1;
            check({req, " valid"}, 32'(rd_valid), 32'd1);
            check({req, " src"}, 32'(rd_src), 32'(pat));
            check({req, " data"}, 32'(rd_data),
                  pat ? (zero ? 32'd0 : ((k % 2) ? 32'hFF : 32'h00)) : 32'(arr_data));
            check({req, " err"}, 32'(err), (k == 0) ? 32'(exp_err) : 32'd0);
            @(negedge clk);
        end
        check({req, " burst end"}, 32'(rd_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all) actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 err", 32'(err), 32'd0);
        check("R1 valid", 32'(rd_valid), 32'd0);
        // R1, R2: normal read after reset
        read_chk("R2 READ normal", 4'd2, 1'b0, 1'b0, 1'b0);
        read_chk("R2 RDAP normal", 4'd3, 1'b0, 1'b0, 1'b0);

        // R4: low bits ignored with enable clear
        send(4'd1, 3'd3, 16'h0003);
        check("R4 err", 32'(err), 32'd0);
        read_chk("R4 read", 4'd2, 1'b0, 1'b0, 1'b0);

        // R5: reserved bits
        send(4'd1, 3'd7, 16'h0004);
        check("R5 ba2 err", 32'(err), 32'd1);
        read_chk("R5 ba2 read", 4'd2, 1'b0, 1'b0, 1'b0);
        send(4'd1, 3'd3, 16'h8004);
        check("R5 a15 err", 32'(err), 32'd1);
        read_chk("R5 a15 read", 4'd2, 1'b0, 1'b0, 1'b0);

        // R6: bank not idle
        bank_idle = 8'hFE;
        send(4'd1, 3'd3, 16'h0004);
        check("R6 err", 32'(err), 32'd1);
        bank_idle = 8'hFF;
        read_chk("R6 read", 4'd2, 1'b0, 1'b0, 1'b0);

        // R7: precharge window, one cycle early then exact
        send(4'd4, 3'd2, 16'h0000);
        check("R7 PRE err", 32'(err), 32'd0);
        repeat (TRP - 2) @(negedge clk);
        send(4'd1, 3'd3, 16'h0004);
        check("R7 early err", 32'(err), 32'd1);
        send(4'd1, 3'd3, 16'h0004);
        check("R7 on-time err", 32'(err), 32'd0);

        // R3: pattern reads
        read_chk("R3 READ pattern", 4'd2, 1'b1, 1'b0, 1'b0);
        read_chk("R3 RDAP pattern", 4'd3, 1'b1, 1'b0, 1'b0);

        // R8: table walk in pattern mode
        for (int i = 0; i < 9; i++) begin
            send(TBL[i].c, TBL[i].b, TBL[i].a);
            check($sformatf("R8 vec%0d err", i), 32'(err), 32'(TBL[i].e));
            read_chk($sformatf("R8 vec%0d mode kept", i), 4'd2, 1'b1, 1'b0, 1'b0);
        end

        // R9: clean exit
        send(4'd1, 3'd3, 16'h0000);
        check("R9 err", 32'(err), 32'd0);
        read_chk("R9 read", 4'd2, 1'b0, 1'b0, 1'b0);

        // R11: reserved pattern code
        send(4'd1, 3'd3, 16'h0005);
        check("R11 enable err", 32'(err), 32'd0);
        read_chk("R11 read", 4'd2, 1'b1, 1'b1, 1'b1);

        // R10: RESET mid-burst in pattern mode
        send(4'd1, 3'd3, 16'h0000);
        send(4'd1, 3'd3, 16'h0004);
        check("R10 enable err", 32'(err), 32'd0);
        send(4'd2, 3'd0, 16'h0000);
        repeat (2) @(negedge clk);
        check("R10 mid-burst valid", 32'(rd_valid), 32'd1);
        send(4'd9, 3'd0, 16'h0000);
        check("R10 burst ended", 32'(rd_valid), 32'd0);
        check("R10 err", 32'(err), 32'd0);
        read_chk("R10 read normal", 4'd2, 1'b0, 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule